// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block gives a chip a set of general-purpose pin banks, each of 32 pins, behind one small memory-mapped register port (write enable, read enable, byte address, 32-bit data). Every bank holds, per pin, an output value, an output-enable bit and a view of the pin's synchronized input level. Banks are placed one after another at a fixed address stride of 0x200 bytes. The bank is chosen by the address bits above bit 8, and the register is chosen by the low nine bits.

Every pin also has an interrupt detector. It can be configured for level or edge sensing, for one edge or both edges, and for high/rising or low/falling polarity. Events latch into a raw status register, which is cleared by writing ones. A per-pin enable mask produces a masked status. The masked status bits of all banks are ORed into one interrupt line. Software reads the masked status, writes each set bit to the clear register, and then services the pin.

Top module: `pin_bank_array`

## Requirements
- R1: After reset every register and status bit is 0. pin_oe and pin_out are all 0, irq is 0, and every readable register returns 0 until a pin or a write changes it.
- R2: The bank is addr[ADDR_W-1:9] and the register offset is addr[8:0]. The offsets are 0x000 input, 0x004 output value, 0x008 output enable, 0x00C sense type, 0x010 dual edge, 0x014 polarity, 0x018 mask, 0x01C raw status, 0x020 masked status and 0x024 clear. rd_data updates on the clock edge at which rd_en is sampled and holds its value otherwise. A bank index of NUM_BANKS or above, or any other offset, reads 0 and ignores writes.
- R3: A write to 0x004 sets the bank's pin_out bits and a write to 0x008 sets its pin_oe bits (1 = drive), both from the next edge. Both registers read back what was written, and pin_oe does not change without a write to 0x008.
- R4: Each pin input passes through two synchronizing flops. Offset 0x000 returns the synchronized level, so a level held for two edges is visible to a read.
- R5: With the sense-type bit at 0 (edge) and the dual-edge bit at 0, a polarity bit of 1 latches raw status on a rising edge and 0 latches it on a falling edge. A latched bit stays set until cleared.
- R6: With the dual-edge bit at 1 in edge mode, both rising and falling edges latch status, whatever the polarity bit holds.
- R7: With the sense-type bit at 1 (level), status is set on every cycle the synchronized pin equals its polarity bit (1 = high, 0 = low). A clear therefore has no lasting effect while the pin stays active.
- R8: A mask bit of 1 enables the pin. Offset 0x020 reads raw status AND mask, and irq is the OR of the masked status bits of all banks.
- R9: Writing 1 to a bit of 0x024 clears that raw status bit and writing 0 leaves it unchanged. The register reads back 0. When an event and a clear hit the same bit in the same cycle, the bit remains set.
- R10: Writes to 0x000, 0x01C and 0x020 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address: bank index above bit 8, register offset in bits 8:0 |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*32 | Pin input levels, bank b in bits b*32+31 down to b*32 |
| pin_out | output | NUM_BANKS*32 | Pin output values |
| pin_oe | output | NUM_BANKS*32 | Pin output enables, 1 = drive |
| irq | output | 1 | OR of all masked status bits |

## Verification
The in-RTL assertions check on every cycle the following rules:
- Latched edge status never drops without a clear.
- A clear with no event removes the bit on the next edge.
- An active level pin always shows status on the following cycle.
- The output enables only change on a write to their offset.
- The clear offset always reads back zero.

Only the bench's scenarios can show the rest:
- The address decode across banks and unmapped space.
- The synchronizer latency.
- The choice among rising, falling and dual edges.
- The masking feeding irq.
- The rule that an event wins over a clear in the same cycle.

The bench shows these by comparing outputs and every read against a behavioural model, both in directed sequences and under random traffic.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
    localparam int unsigned PINS  = 32;
    localparam int unsigned OFF_W = 9;   // 0x200-byte stride per bank

    localparam logic [OFF_W-1:0] OFF_IN    = 9'h000;
    localparam logic [OFF_W-1:0] OFF_OUT   = 9'h004;
    localparam logic [OFF_W-1:0] OFF_OE    = 9'h008;
    localparam logic [OFF_W-1:0] OFF_LVL   = 9'h00C;
    localparam logic [OFF_W-1:0] OFF_DUAL  = 9'h010;
    localparam logic [OFF_W-1:0] OFF_POL   = 9'h014;
    localparam logic [OFF_W-1:0] OFF_MASK  = 9'h018;
    localparam logic [OFF_W-1:0] OFF_RAW   = 9'h01C;
    localparam logic [OFF_W-1:0] OFF_MSTAT = 9'h020;
    localparam logic [OFF_W-1:0] OFF_CLR   = 9'h024;

    typedef struct packed {
        logic [PINS-1:0] dout;
        logic [PINS-1:0] oe;
        logic [PINS-1:0] lvl;
        logic [PINS-1:0] dual;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] mask;
        logic [PINS-1:0] stat;
        logic [PINS-1:0] prev;
    } bank_state_t;
endpackage

// File: rtl/pin_sync2.sv
module pin_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dual,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        assign rise = cur[i] & ~prev[i];
        assign fall = ~cur[i] & prev[i];
        always_comb begin
            if (lvl[i])       hit[i] = (cur[i] == pol[i]);
            else if (dual[i]) hit[i] = rise | fall;
            else if (pol[i])  hit[i] = rise;
            else              hit[i] = fall;
        end
    end
endmodule

// File: rtl/pin_bank.sv
module pin_bank
    import pbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [PINS-1:0]  wr_data,
    output logic [PINS-1:0]  rd_val,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pin_out,
    output logic [PINS-1:0]  pin_oe,
    output logic             irq
);
    bank_state_t r_d, r_q;
    logic [PINS-1:0] sync_now;
    logic [PINS-1:0] hit;
    logic [PINS-1:0] clr_vec;
    logic            sel_oe;

    pin_sync2 #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_now)
    );

    pin_event_detect #(.W(PINS)) u_det (
        .cur  (sync_now),
        .prev (r_q.prev),
        .lvl  (r_q.lvl),
        .dual (r_q.dual),
        .pol  (r_q.pol),
        .hit  (hit)
    );

    assign sel_oe  = wr_en && (off == OFF_OE);
    assign clr_vec = (wr_en && (off == OFF_CLR)) ? wr_data : '0;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (off)
                OFF_OUT:  r_d.dout = wr_data;
                OFF_OE:   r_d.oe   = wr_data;
                OFF_LVL:  r_d.lvl  = wr_data;
                OFF_DUAL: r_d.dual = wr_data;
                OFF_POL:  r_d.pol  = wr_data;
                OFF_MASK: r_d.mask = wr_data;
                default:  ;
            endcase
        end
        // event wins over a clear of the same bit
        r_d.stat = (r_q.stat & ~clr_vec) | hit;
        r_d.prev = sync_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (off)
            OFF_IN:    rd_val = sync_now;
            OFF_OUT:   rd_val = r_q.dout;
            OFF_OE:    rd_val = r_q.oe;
            OFF_LVL:   rd_val = r_q.lvl;
            OFF_DUAL:  rd_val = r_q.dual;
            OFF_POL:   rd_val = r_q.pol;
            OFF_MASK:  rd_val = r_q.mask;
            OFF_RAW:   rd_val = r_q.stat;
            OFF_MSTAT: rd_val = r_q.stat & r_q.mask;
            default:   rd_val = '0;
        endcase
    end

    assign pin_out = r_q.dout;
    assign pin_oe  = r_q.oe;
    assign irq     = |(r_q.stat & r_q.mask);

    // R5
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(r_q.stat) & ~$past(clr_vec)) & ~r_q.stat) == '0));

    // R9
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(clr_vec) & ~$past(hit)) & r_q.stat) == '0));

    // R7
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(r_q.lvl & ~(sync_now ^ r_q.pol)) & ~r_q.stat) == '0));

    // R3
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_oe |=> $stable(r_q.oe));
endmodule

// File: rtl/pin_bank_array.sv
module pin_bank_array
    import pbk_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wr_data,
    output logic [31:0]               rd_data,
    input  logic [NUM_BANKS*PINS-1:0] pin_in,
    output logic [NUM_BANKS*PINS-1:0] pin_out,
    output logic [NUM_BANKS*PINS-1:0] pin_oe,
    output logic                      irq
);
    localparam int BANK_W = ADDR_W - OFF_W;

    logic [BANK_W-1:0]   bank_idx;
    logic [OFF_W-1:0]    off;
    logic [PINS-1:0]     bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;
    logic [31:0]         rd_mux;
    logic [31:0]         rd_d, rd_q;

    assign bank_idx = addr[ADDR_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && (bank_idx == BANK_W'(b));
        pin_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .off     (off),
            .wr_data (wr_data),
            .rd_val  (bank_rd[b]),
            .pin_in  (pin_in[b*PINS +: PINS]),
            .pin_out (pin_out[b*PINS +: PINS]),
            .pin_oe  (pin_oe[b*PINS +: PINS]),
            .irq     (bank_irq[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_W'(b)) rd_mux = bank_rd[b];
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
    assign irq     = |bank_irq;

    // R9
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (off == OFF_CLR)) |=> (rd_data == '0));
endmodule

// File: tb/pin_bank_array_test.sv
`timescale 1ns/100ps
module pin_bank_array_test;
    localparam int NB = 2;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [NB*32-1:0] pins = '0;
    logic [31:0] rd_data;
    logic [NB*32-1:0] pin_out, pin_oe;
    logic irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pin_bank_array #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wdata), .rd_data(rd_data), .pin_in(pins), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_s1[NB], m_s2[NB], m_pv[NB];
    logic [31:0] m_out[NB], m_oe[NB], m_typ[NB], m_dual[NB], m_pol[NB], m_mask[NB], m_st[NB];
    logic [31:0] m_rd;
    bit          rd_pend;
    logic [8:0]  rd_off;
    int          rd_bank;

    function automatic logic [31:0] m_read(int b, logic [8:0] o);
        if (b >= NB) return 32'h0;
        case (o)
            9'h000: return m_s2[b];
            9'h004: return m_out[b];
            9'h008: return m_oe[b];
            9'h00C: return m_typ[b];
            9'h010: return m_dual[b];
            9'h014: return m_pol[b];
            9'h018: return m_mask[b];
            9'h01C: return m_st[b];
            9'h020: return m_st[b] & m_mask[b];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_s1[b] = 0; m_s2[b] = 0; m_pv[b] = 0; m_out[b] = 0; m_oe[b] = 0;
                m_typ[b] = 0; m_dual[b] = 0; m_pol[b] = 0; m_mask[b] = 0; m_st[b] = 0;
            end
            m_rd = 0; rd_pend = 0;
        end else begin
            rd_pend = rd_en;
            if (rd_en) begin
                rd_bank = int'(addr[AW-1:9]);
                rd_off  = addr[8:0];
                m_rd    = m_read(rd_bank, rd_off);
            end
            for (int b = 0; b < NB; b++) begin
                logic [31:0] h, clr;
                bit sel;
                sel = wr_en && (int'(addr[AW-1:9]) == b);
                h = 0;
                for (int i = 0; i < 32; i++) begin
                    if (m_typ[b][i])       h[i] = (m_s2[b][i] == m_pol[b][i]);
                    else if (m_dual[b][i]) h[i] = (m_s2[b][i] != m_pv[b][i]);
                    else if (m_pol[b][i])  h[i] = m_s2[b][i] && !m_pv[b][i];
                    else                   h[i] = !m_s2[b][i] && m_pv[b][i];
                end
                clr = (sel && addr[8:0] == 9'h024) ? wdata : 32'h0;
                m_st[b] = (m_st[b] & ~clr) | h;
                if (sel) begin
                    case (addr[8:0])
                        9'h004: m_out[b]  = wdata;
                        9'h008: m_oe[b]   = wdata;
                        9'h00C: m_typ[b]  = wdata;
                        9'h010: m_dual[b] = wdata;
                        9'h014: m_pol[b]  = wdata;
                        9'h018: m_mask[b] = wdata;
                        default: ;
                    endcase
                end
                m_pv[b] = m_s2[b];
                m_s2[b] = m_s1[b];
                m_s1[b] = pins[b*32 +: 32];
            end
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(int b, logic [8:0] o);
        if (b >= NB) return "R2";
        case (o)
            9'h000: return "R4";
            9'h004, 9'h008: return "R3";
            9'h00C, 9'h010, 9'h014: return "R5";
            9'h018, 9'h020: return "R8";
            9'h01C: return "R6";
            9'h024: return "R9";
            default: return "R2";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [63:0] e_out, e_oe;
            logic e_irq;
            e_irq = 0;
            for (int b = 0; b < NB; b++) begin
                e_out[b*32 +: 32] = m_out[b];
                e_oe[b*32 +: 32]  = m_oe[b];
                e_irq = e_irq | (|(m_st[b] & m_mask[b]));
            end
            check("R3", "pin_out", pin_out, e_out);
            check("R3", "pin_oe", pin_oe, e_oe);
            check("R8", "irq", {63'h0, irq}, {63'h0, e_irq});
            if (rd_pend) check(req_of(rd_bank, rd_off), "rd_data", {32'h0, rd_data}, {32'h0, m_rd});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_pins(input logic [NB*32-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "pin_oe after reset", pin_oe, 64'h0);
        check("R1", "irq after reset", {63'h0, irq}, 64'h0);
        for (int o = 0; o <= 9'h024; o += 4) begin
            do_read(AW'(o), v);
            check("R1", "register after reset", {32'h0, v}, 64'h0);
        end

        // R3 output value and enable
        do_write(12'h004, 32'hA5A5_0F0F);
        do_write(12'h008, 32'hFFFF_0000);
        do_read(12'h008, v);
        check("R3", "oe readback", {32'h0, v}, 64'hFFFF_0000);
        check("R3", "pin_out bank0", {32'h0, pin_out[31:0]}, 64'hA5A5_0F0F);

        // R2 bank stride, unmapped space
        do_write(12'h204, 32'h0000_1234);
        do_read(12'h204, v);
        check("R2", "bank1 out readback", {32'h0, v}, 64'h1234);
        check("R2", "bank1 pin_out", {32'h0, pin_out[63:32]}, 64'h1234);
        do_write(12'h404, 32'hDEAD_BEEF);
        do_read(12'h404, v);
        check("R2", "out-of-range bank read", {32'h0, v}, 64'h0);
        do_read(12'h028, v);
        check("R2", "unmapped offset read", {32'h0, v}, 64'h0);
        do_read(12'h004, v);
        check("R2", "bank0 untouched by bank1 write", {32'h0, v}, 64'hA5A5_0F0F);

        // R4 synchronized input, R10 read-only registers
        set_pins({32'h8000_0001, 32'h0000_00F0});
        do_read(12'h000, v);
        check("R4", "bank0 input", {32'h0, v}, 64'hF0);
        do_read(12'h200, v);
        check("R4", "bank1 input", {32'h0, v}, 64'h8000_0001);
        do_write(12'h000, 32'hFFFF_FFFF);
        do_read(12'h000, v);
        check("R10", "write to input ignored", {32'h0, v}, 64'hF0);

        // interrupt setup on bank0: pin0 rise, pin1 fall, pin2 dual, pin3 level high, pin4 level low
        set_pins(64'h10);
        do_write(12'h00C, 32'h18);
        do_write(12'h010, 32'h4);
        do_write(12'h014, 32'h9);
        do_write(12'h024, 32'hFFFF_FFFF);
        do_read(12'h01C, v);
        check("R7", "inactive level pins no status", {32'h0, v}, 64'h0);
        do_write(12'h018, 32'h1F);
        check("R8", "irq low with no status", {63'h0, irq}, 64'h0);

        set_pins(64'h17);
        do_read(12'h01C, v);
        check("R5", "rise on pin0 only, pin1 fall-polarity quiet", {32'h0, v}, 64'h5);
        check("R6", "dual edge pin2 set on rise", {63'h0, v[2]}, 64'h1);
        check("R8", "irq raised", {63'h0, irq}, 64'h1);
        do_write(12'h01C, 32'h0);
        do_write(12'h020, 32'h0);
        do_read(12'h01C, v);
        check("R10", "raw status write ignored", {32'h0, v}, 64'h5);

        do_write(12'h024, 32'h0);
        do_read(12'h01C, v);
        check("R9", "zero clear no effect", {32'h0, v}, 64'h5);
        do_write(12'h024, 32'h4);
        set_pins(64'h11);
        do_read(12'h01C, v);
        check("R5", "fall on pin1", {63'h0, v[1]}, 64'h1);
        check("R6", "dual edge pin2 set on fall", {63'h0, v[2]}, 64'h1);

        set_pins(64'h19);
        do_read(12'h01C, v);
        check("R7", "level high pin3 set", {32'h0, v}, 64'hF);
        do_write(12'h024, 32'hF);
        do_read(12'h01C, v);
        check("R7", "active level survives clear", {32'h0, v}, 64'h8);
        do_read(12'h024, v);
        check("R9", "clear reads zero", {32'h0, v}, 64'h0);
        set_pins(64'h11);
        do_write(12'h024, 32'h8);
        do_read(12'h01C, v);
        check("R9", "clear after level inactive", {32'h0, v}, 64'h0);
        check("R8", "irq low after clear", {63'h0, irq}, 64'h0);

        // R8 masked status
        set_pins(64'h10);
        set_pins(64'h16);
        do_write(12'h018, 32'h2);
        do_read(12'h020, v);
        check("R8", "masked status", {32'h0, v}, 64'h0);
        do_read(12'h01C, v);
        check("R8", "raw status with mask", {32'h0, v}, 64'h4);
        do_write(12'h018, 32'h4);
        do_read(12'h020, v);
        check("R8", "masked status enabled bit", {32'h0, v}, 64'h4);
        do_write(12'h024, 32'hFFFF_FFFF);

        // R9 edge and clear in the same cycle: edge wins
        do_write(12'h00C, 32'h0);
        do_write(12'h010, 32'h0);
        do_write(12'h014, 32'h1);
        @(negedge clk); pins = 64'h0;
        repeat (4) @(negedge clk);
        do_write(12'h024, 32'hFFFF_FFFF);
        @(negedge clk); pins = 64'h1;
        @(posedge clk); @(posedge clk);
        do_write(12'h024, 32'h1);
        do_read(12'h01C, v);
        check("R9", "edge wins over same-cycle clear", {63'h0, v[0]}, 64'h1);

        // random traffic, checked every cycle against the model
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [AW-1:0] a;
            op = $urandom_range(0, 3);
            a = {AW'($urandom_range(0, 2)) << 9} | AW'(4 * $urandom_range(0, 10));
            case (op)
                0: do_write(a, $urandom());
                1: begin do_read(a, v); end
                2: begin @(negedge clk); pins = {$urandom(), $urandom()}; end
                default: do_write((a & 12'hE00) | 12'h024, $urandom());
            endcase
        end
        repeat (4) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end
endmodule